// File: doc/BRIEF.md
# Integer ALU with Relational Set Operations

This block is the combinational integer execution unit of a 32-bit load/store processor. Each cycle it takes two operands and an operation code and returns a result word together with a signed-overflow trap flag. Choosing between a register and a sign-extended 16-bit immediate for the second operand happens before the block. Operand B therefore already holds a 32-bit value when an immediate form is executed.

The block covers bitwise logic, modular add and subtract, logical and arithmetic shifts, and placing an immediate in the upper half of a word. It also has six relational set operations, which write a single 0 or 1 into the result. The add and subtract come in a trapping form and a non-trapping form. The two forms produce the same result word; only the trapping form raises the flag. Because the unit holds no state, the result and flag follow the inputs within the same cycle.

Top module: `int_alu`

## Requirements
- R1: Operation codes 4, 5 and 6 return the bitwise AND, OR and XOR of A and B, with no trap.
- R2: Codes 0 and 1 return (A + B) mod 2^32. Codes 2 and 3 return (A - B) mod 2^32.
- R3: The trap output is 1 only for code 0 or code 2, and only when the two's-complement result does not fit in 32 bits. Codes 1 and 3 never trap. The result word is still delivered when the trap is raised.
- R4: Code 7 shifts A left and code 8 shifts A right, filling with zeros. The shift amount is B[4:0] and the upper bits of B are ignored.
- R5: Code 9 shifts A right by B[4:0] and fills the vacated bits with copies of A[31].
- R6: Code 10 returns B[15:0] in bits 31..16 and zeros in bits 15..0. A has no effect on the result.
- R7: Codes 11 to 16 compare A with B as signed numbers, testing less-than, greater-than, less-or-equal, greater-or-equal, equal and not-equal in that order. The result is 1 when the test holds and 0 otherwise, and these codes never trap.
- R8: Codes 17 to 31 return zero with no trap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code (see requirements) |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand (register or sign-extended immediate) |
| result_o | output | 32 | Operation result |
| ovf_trap_o | output | 1 | Signed overflow trap for the trapping add and subtract |

## Verification
The unit holds no state, so an internal fault shows up in the same cycle as the operands that reach it. A wrong carry-in or operand inversion in the adder shows as an off-by-one or sign-flipped sum. The cases at the 0x7FFFFFFF/0x80000000 boundary expose a wrong overflow term, or a trap that fires on the non-trapping codes. In the shifter, a stage with the wrong fill shows up only for particular shift amounts, so every amount from 0 to 31 is applied to each shift direction. Mixing up the less-than and equal terms in the comparator changes only the boundary relations, so equal and extreme-sign operand pairs are applied.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

   localparam int OP_W = 5;

   typedef enum logic [OP_W-1:0] {
      OP_ADD  = 5'd0,
      OP_ADDU = 5'd1,
      OP_SUB  = 5'd2,
      OP_SUBU = 5'd3,
      OP_AND  = 5'd4,
      OP_OR   = 5'd5,
      OP_XOR  = 5'd6,
      OP_SLL  = 5'd7,
      OP_SRL  = 5'd8,
      OP_SRA  = 5'd9,
      OP_LHI  = 5'd10,
      OP_SLT  = 5'd11,
      OP_SGT  = 5'd12,
      OP_SLE  = 5'd13,
      OP_SGE  = 5'd14,
      OP_SEQ  = 5'd15,
      OP_SNE  = 5'd16
   } alu_op_e;

   typedef enum logic [2:0] {
      REL_LT = 3'd0,
      REL_GT = 3'd1,
      REL_LE = 3'd2,
      REL_GE = 3'd3,
      REL_EQ = 3'd4,
      REL_NE = 3'd5
   } rel_e;

   typedef enum logic [1:0] {
      LOG_AND = 2'd0,
      LOG_OR  = 2'd1,
      LOG_XOR = 2'd2
   } logic_e;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         ovf
);
   localparam int MSB = W - 1;

   logic [W-1:0] b_eff;
   logic [W:0]   wide;

   always_comb begin
      b_eff = sub ? ~b : b;
      wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, sub};
      sum   = wide[W-1:0];
      ovf   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
   end

   // R3: two operands of opposite true sign can never overflow an add
   always_comb begin
      if (!sub && (a[MSB] != b[MSB]))
         p_no_overflow_mixed_r3: assert (!ovf);
   end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
   parameter int W      = 32,
   parameter bit STAGED = 1'b1,
   localparam int SH_W  = $clog2(W)
) (
   input  logic [W-1:0]    val,
   input  logic [SH_W-1:0] amt,
   input  logic            left,
   input  logic            arith,
   output logic [W-1:0]    res
);
   if (W < 2 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("alu_shifter: W must be a power of two of at least 2");
   end

   function automatic logic [W-1:0] flip(input logic [W-1:0] x);
      logic [W-1:0] y;
      for (int i = 0; i < W; i++) y[i] = x[W-1-i];
      return y;
   endfunction

   if (STAGED) begin : g_staged
      logic [W-1:0] cur;
      logic         fill;
      always_comb begin
         fill = arith && !left && val[W-1];
         cur  = left ? flip(val) : val;
         for (int s = 0; s < SH_W; s++) begin
            if (amt[s]) begin
               cur = (cur >> (1 << s)) |
                     (fill ? ~({W{1'b1}} >> (1 << s)) : {W{1'b0}});
            end
         end
         res = left ? flip(cur) : cur;
      end
   end else begin : g_operator
      always_comb begin
         if (left)       res = val << amt;
         else if (arith) res = $unsigned($signed(val) >>> amt);
         else            res = val >> amt;
      end
   end

   // R4: a zero shift amount passes the operand through untouched
   always_comb begin
      if (amt == '0)
         p_zero_shift_identity_r4: assert (res == val);
   end

endmodule

// File: rtl/alu_setcmp.sv
module alu_setcmp
   import int_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  rel_e         rel,
   output logic [W-1:0] res
);
   logic lt, eq, hit;

   always_comb begin
      lt = $signed(a) < $signed(b);
      eq = (a == b);
      unique case (rel)
         REL_LT:  hit = lt;
         REL_GT:  hit = !lt && !eq;
         REL_LE:  hit = lt || eq;
         REL_GE:  hit = !lt;
         REL_EQ:  hit = eq;
         REL_NE:  hit = !eq;
         default: hit = 1'b0;
      endcase
      res = {{(W-1){1'b0}}, hit};
   end

   // R7: equal operands satisfy exactly the LE, GE and EQ relations
   always_comb begin
      if (a == b)
         p_equal_rel_r7: assert (res[0] == (rel == REL_LE || rel == REL_GE || rel == REL_EQ));
   end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
   import int_alu_pkg::*;
#(
   parameter int W = 32
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic_e       fn,
   output logic [W-1:0] res
);
   always_comb begin
      unique case (fn)
         LOG_AND: res = a & b;
         LOG_OR:  res = a | b;
         LOG_XOR: res = a ^ b;
         default: res = '0;
      endcase
   end

   // R1: an AND result never has a bit that is clear in either operand
   always_comb begin
      if (fn == LOG_AND)
         p_and_subset_r1: assert (((res & ~a) | (res & ~b)) == '0);
   end

endmodule

// File: rtl/int_alu.sv
module int_alu
   import int_alu_pkg::*;
#(
   parameter int DATA_W       = 32,
   parameter int IMM_W        = 16,
   parameter bit SHIFT_STAGED = 1'b1,
   localparam int SH_W        = $clog2(DATA_W)
) (
   input  logic [OP_W-1:0]   op_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] result_o,
   output logic              ovf_trap_o
);
   if (DATA_W < 2 * IMM_W) begin : g_bad_imm
      $error("int_alu: DATA_W must hold two immediates");
   end

   alu_op_e op;
   logic    sub, sh_left, sh_arith, add_ovf;
   rel_e    rel;
   logic_e  lfn;

   logic [DATA_W-1:0] sum, sh_res, cmp_res, log_res, hi_res;

   always_comb begin
      op       = alu_op_e'(op_i);
      sub      = (op == OP_SUB) || (op == OP_SUBU);
      sh_left  = (op == OP_SLL);
      sh_arith = (op == OP_SRA);
      unique case (op)
         OP_SGT:  rel = REL_GT;
         OP_SLE:  rel = REL_LE;
         OP_SGE:  rel = REL_GE;
         OP_SEQ:  rel = REL_EQ;
         OP_SNE:  rel = REL_NE;
         default: rel = REL_LT;
      endcase
      unique case (op)
         OP_OR:   lfn = LOG_OR;
         OP_XOR:  lfn = LOG_XOR;
         default: lfn = LOG_AND;
      endcase
      hi_res = {b_i[IMM_W-1:0], {(DATA_W-IMM_W){1'b0}}} & {{IMM_W{1'b1}}, {(DATA_W-IMM_W){1'b0}}};
   end

   alu_addsub #(.W(DATA_W)) u_addsub (
      .a(a_i), .b(b_i), .sub(sub), .sum(sum), .ovf(add_ovf)
   );

   alu_shifter #(.W(DATA_W), .STAGED(SHIFT_STAGED)) u_shift (
      .val(a_i), .amt(b_i[SH_W-1:0]), .left(sh_left), .arith(sh_arith), .res(sh_res)
   );

   alu_setcmp #(.W(DATA_W)) u_cmp (
      .a(a_i), .b(b_i), .rel(rel), .res(cmp_res)
   );

   alu_logic #(.W(DATA_W)) u_logic (
      .a(a_i), .b(b_i), .fn(lfn), .res(log_res)
   );

   always_comb begin
      unique case (op)
         OP_ADD, OP_ADDU, OP_SUB, OP_SUBU: result_o = sum;
         OP_AND, OP_OR, OP_XOR:            result_o = log_res;
         OP_SLL, OP_SRL, OP_SRA:           result_o = sh_res;
         OP_LHI:                           result_o = hi_res;
         OP_SLT, OP_SGT, OP_SLE,
         OP_SGE, OP_SEQ, OP_SNE:           result_o = cmp_res;
         default:                          result_o = '0;
      endcase
      ovf_trap_o = add_ovf && ((op == OP_ADD) || (op == OP_SUB));
   end

   // R3: a trap only ever accompanies the trapping add and subtract codes
   always_comb begin
      if (ovf_trap_o)
         p_trap_signed_only_r3: assert (op_i == 5'd0 || op_i == 5'd2);
   end

   // R6: the upper-half load leaves the lower half clear
   always_comb begin
      if (op_i == 5'd10)
         p_lhi_low_clear_r6: assert (result_o[DATA_W-IMM_W-1:0] == '0);
   end

   // R8: unassigned codes give a zero word and no trap
   always_comb begin
      if (op_i > 5'd16)
         p_unused_zero_r8: assert (result_o == '0 && !ovf_trap_o);
   end

endmodule

// File: tb/int_alu_bench.sv
module int_alu_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  op;
   logic [31:0] a, b;
   logic [31:0] result;
   logic        trap;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   int_alu u_int_alu (
      .op_i(op), .a_i(a), .b_i(b), .result_o(result), .ovf_trap_o(trap)
   );

   // fields: op[101:97] a[96:65] b[64:33] expected result[32:1] expected trap[0]
   localparam int NV = 24;
   localparam logic [101:0] VEC [NV] = '{
      {5'd0,  32'h7fffffff, 32'h00000001, 32'h80000000, 1'b1}, // R3 add overflow
      {5'd1,  32'h7fffffff, 32'h00000001, 32'h80000000, 1'b0}, // R3 unsigned no trap
      {5'd0,  32'hffffffff, 32'h00000001, 32'h00000000, 1'b0}, // R2 carry only
      {5'd2,  32'h80000000, 32'h00000001, 32'h7fffffff, 1'b1}, // R3 sub overflow
      {5'd3,  32'h80000000, 32'h00000001, 32'h7fffffff, 1'b0}, // R3 unsigned sub
      {5'd2,  32'h00000005, 32'h00000007, 32'hfffffffe, 1'b0}, // R2 negative diff
      {5'd4,  32'hf0f0ff00, 32'h0ff0f0f0, 32'h00f0f000, 1'b0}, // R1
      {5'd5,  32'hf0f0ff00, 32'h0ff0f0f0, 32'hfff0fff0, 1'b0}, // R1
      {5'd6,  32'hf0f0ff00, 32'h0ff0f0f0, 32'hff000ff0, 1'b0}, // R1
      {5'd7,  32'h00000001, 32'h00000024, 32'h00000010, 1'b0}, // R4 amount uses low 5 bits
      {5'd8,  32'h80000000, 32'h0000001f, 32'h00000001, 1'b0}, // R4
      {5'd9,  32'h80000000, 32'h00000004, 32'hf8000000, 1'b0}, // R5
      {5'd9,  32'h7ffffff0, 32'h00000020, 32'h7ffffff0, 1'b0}, // R5 amount 32 -> 0
      {5'd10, 32'hdeadbeef, 32'hffff1234, 32'h12340000, 1'b0}, // R6
      {5'd11, 32'hffffffff, 32'h00000001, 32'h00000001, 1'b0}, // R7 signed lt
      {5'd12, 32'hffffffff, 32'h00000001, 32'h00000000, 1'b0}, // R7
      {5'd13, 32'h00000005, 32'h00000005, 32'h00000001, 1'b0}, // R7
      {5'd14, 32'h80000000, 32'h7fffffff, 32'h00000000, 1'b0}, // R7
      {5'd15, 32'h00000005, 32'h00000005, 32'h00000001, 1'b0}, // R7
      {5'd16, 32'h00000005, 32'h00000005, 32'h00000000, 1'b0}, // R7
      {5'd12, 32'h00000001, 32'hffffffff, 32'h00000001, 1'b0}, // R7
      {5'd31, 32'h7fffffff, 32'h00000001, 32'h00000000, 1'b0}, // R8
      {5'd2,  32'h7fffffff, 32'hffffffff, 32'h80000000, 1'b1}, // R3
      {5'd0,  32'h80000000, 32'h80000000, 32'h00000000, 1'b1}  // R3
   };

   function automatic string tag_of(input logic [4:0] c, input logic t);
      if (t || c == 5'd1 || c == 5'd3) return "R3";
      if (c <= 5'd3)  return "R2";
      if (c <= 5'd6)  return "R1";
      if (c <= 5'd8)  return "R4";
      if (c == 5'd9)  return "R5";
      if (c == 5'd10) return "R6";
      if (c <= 5'd16) return "R7";
      return "R8";
   endfunction

   task automatic apply(input logic [4:0] o, input logic [31:0] x, input logic [31:0] y);
      @(posedge clk);
      op = o; a = x; b = y;
      @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [31:0] er, input logic et);
      checks++;
      if (result !== er || trap !== et) begin
         fails++;
         $display("FAIL %s: op=%0d result=%h trap=%b expected result=%h trap=%b",
                  tag, op, result, trap, er, et);
      end
   endtask

   initial begin
      op = 5'd0; a = '0; b = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R2: zero operands after reset give a zero sum
      apply(5'd0, 32'h0, 32'h0);
      chk("R2", 32'h0, 1'b0);

      for (int i = 0; i < NV; i++) begin
         apply(VEC[i][101:97], VEC[i][96:65], VEC[i][64:33]);
         chk(tag_of(VEC[i][101:97], VEC[i][0]), VEC[i][32:1], VEC[i][0]);
      end

      // R4 and R5: every shift amount, garbage in the upper bits of B
      for (int k = 0; k < 32; k++) begin
         logic [31:0] x;
         x = 32'h80000001;
         apply(5'd7, x, {27'h5a5a5a5, k[4:0]});
         chk("R4", x << k, 1'b0);
         apply(5'd8, x, {27'h5a5a5a5, k[4:0]});
         chk("R4", x >> k, 1'b0);
         apply(5'd9, x, {27'h5a5a5a5, k[4:0]});
         chk("R5", 32'($signed(x) >>> k), 1'b0);
      end

      // R6: A has no effect on the upper-half load
      apply(5'd10, 32'h00000000, 32'h0000abcd);
      chk("R6", 32'habcd0000, 1'b0);
      apply(5'd10, 32'hffffffff, 32'h0000abcd);
      chk("R6", 32'habcd0000, 1'b0);

      // R8: every unassigned code
      for (int c = 17; c < 32; c++) begin
         apply(c[4:0], 32'h80000000, 32'h80000000);
         chk("R8", 32'h0, 1'b0);
      end

      // R7: extreme signs never trap and give 0/1
      apply(5'd11, 32'h80000000, 32'h7fffffff);
      chk("R7", 32'h1, 1'b0);
      apply(5'd14, 32'h7fffffff, 32'h80000000);
      chk("R7", 32'h1, 1'b0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: result=%h trap=%b expected completion", result, trap);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule